// File: doc/BRIEF.md
# USB Endpoint Buffer Allocator

This block decides where each endpoint buffer of a USB device sits inside one shared packet memory. Two buffers belong to the control endpoint (its OUT and its IN half). Each is fixed at 64 bytes and never doubled. Fourteen further endpoints are configured through a byte-wide register write port. Each configurable endpoint has an enable bit, a size code, an isochronous flag, a transfer direction and a double-buffer flag. The block outputs a base address and an allocated length for all sixteen buffers.

Buffers are packed back to back in a fixed order: control OUT, control IN, then endpoints 1 through 14. A disabled endpoint takes no space. A write that changes the layout starts a sequential recomputation, one buffer per clock, and a busy flag covers it. When the recomputation ends, the block compares the total with the 2462-byte pool and reports any excess. A layout-changing write also drops every buffer-valid flag, because the data held in the memory no longer sits where the map says. A packet engine outside the block raises the valid flags by pulsing per-buffer fill inputs.

Top module: `usb_ep_alloc`

## Requirements
- R1: Buffer 0 (control OUT) and buffer 1 (control IN) always have length 64. Once the layout is settled, their bases are 0 and 64. On `dir_o`, bit 0 reads 0 (OUT) and bit 1 reads 1 (IN).
- R2: A write with `cfg_ep` between 1 and 14 stores `cfg_wdata` for that endpoint, which occupies buffer index `cfg_ep`+1. The field positions are: bit 0 enable, bit 1 isochronous, bit 2 direction (1 = IN), bit 3 double buffer, bits 7:4 size code. Writes to `cfg_ep` 0 or 15 are ignored.
- R3: With the isochronous bit clear, size codes 0, 1, 2 and 3 give 8, 16, 32 and 64 bytes. Every higher code gives 64 bytes.
- R4: With the isochronous bit set, size codes 0 to 15 give 16, 32, 48, 64, 96, 128, 160, 192, 256, 320, 384, 512, 640, 768, 896 and 1023 bytes.
- R5: An enabled endpoint with the double-buffer bit set has twice its packet size as length.
- R6: A disabled endpoint has length 0.
- R7: When busy is low, each base equals the sum of the lengths of all buffers of lower index.
- R8: A write that changes the layout raises busy at the next edge, and busy stays high for exactly 16 cycles. A second such write while busy restarts the 16-cycle count. A write that changes only the direction bit, or only fields of an endpoint that stays disabled, leaves busy low.
- R9: When busy falls, `overflow_o` is high if and only if the sum of all 16 lengths exceeds 2462.
- R10: A layout-changing write clears all 16 valid flags at the next edge. A direction-only write, or a write to an endpoint that stays disabled, leaves the valid flags unchanged.
- R11: A `fill_set` bit sets its buffer's valid flag only when busy is low and the buffer's length is nonzero.
- R12: After synchronous reset, all configurable endpoints are disabled and the valid flags are clear. After the 16-cycle recomputation, buffers 2 to 15 have base 128 and length 0, and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Endpoint number addressed by the write |
| cfg_wdata | input | 8 | Endpoint configuration byte |
| fill_set | input | 16 | Per-buffer pulse marking the buffer's contents valid |
| base_o | output | 256 | Sixteen 16-bit base addresses, buffer 0 in the low bits |
| len_o | output | 256 | Sixteen 16-bit allocated lengths, buffer 0 in the low bits |
| dir_o | output | 16 | Per-buffer direction, 1 = IN |
| valid_o | output | 16 | Per-buffer contents-valid flags |
| busy_o | output | 1 | Layout recomputation in progress |
| overflow_o | output | 1 | Allocated total exceeds pool capacity |

## Verification
The assertions check the following on every cycle:
- Whenever busy is low, each base chains onto the one before it.
- The control buffers are fixed.
- Overflow agrees with the final base plus length.
- Every layout change empties the valid flags.
- An out-of-range write leaves the stored configuration untouched.
- No valid flag stands on a zero-length buffer.

Only the bench's scenarios can show the following: the two size tables, the exact 16-cycle busy window and its restart, and the exact 2462-byte boundary of the overflow flag. The same holds for the cases that must not disturb the layout: direction-only writes, writes to disabled endpoints, and fills attempted while busy.

// File: rtl/usb_ep_alloc_pkg.sv
package usb_ep_alloc_pkg;

  typedef struct packed {
    logic [3:0] size;
    logic       dbl;
    logic       dir;
    logic       iso;
    logic       en;
  } ep_cfg_t;

  function automatic logic [10:0] pkt_bytes(input logic [3:0] code, input logic iso);
    logic [10:0] b;
    if (!iso) begin
      case (code)
        4'd0:    b = 11'd8;
        4'd1:    b = 11'd16;
        4'd2:    b = 11'd32;
        default: b = 11'd64;
      endcase
    end else begin
      case (code)
        4'd0:    b = 11'd16;
        4'd1:    b = 11'd32;
        4'd2:    b = 11'd48;
        4'd3:    b = 11'd64;
        4'd4:    b = 11'd96;
        4'd5:    b = 11'd128;
        4'd6:    b = 11'd160;
        4'd7:    b = 11'd192;
        4'd8:    b = 11'd256;
        4'd9:    b = 11'd320;
        4'd10:   b = 11'd384;
        4'd11:   b = 11'd512;
        4'd12:   b = 11'd640;
        4'd13:   b = 11'd768;
        4'd14:   b = 11'd896;
        default: b = 11'd1023;
      endcase
    end
    return b;
  endfunction

  function automatic logic [11:0] slot_bytes(input ep_cfg_t c);
    logic [11:0] p;
    p = {1'b0, pkt_bytes(c.size, c.iso)};
    if (!c.en) return 12'd0;
    return c.dbl ? (p << 1) : p;
  endfunction

  function automatic logic [6:0] layout_key(input ep_cfg_t c);
    return c.en ? {1'b1, c.iso, c.dbl, c.size} : 7'd0;
  endfunction

endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import usb_ep_alloc_pkg::*;
#(
  parameter int NUM_CFG   = 14,
  parameter int SUM_W     = 16,
  parameter int EP0_BYTES = 64,
  localparam int NEP  = NUM_CFG + 2,
  localparam int EP_W = $clog2(NUM_CFG + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [EP_W-1:0]      wr_ep,
  input  logic [7:0]           wr_data,
  output logic [NEP*SUM_W-1:0] len_flat,
  output logic [NUM_CFG-1:0]   dir_cfg,
  output logic                 layout_chg
);

  logic [NUM_CFG-1:0][7:0] cfg_q;
  logic [NUM_CFG-1:0]      hit;
  logic [NUM_CFG-1:0]      chg_vec;

  always_comb begin
    for (int i = 0; i < NUM_CFG; i++) begin
      hit[i]     = wr_en && (wr_ep == EP_W'(i + 1));
      chg_vec[i] = hit[i] && (layout_key(ep_cfg_t'(wr_data)) != layout_key(ep_cfg_t'(cfg_q[i])));
    end
  end

  assign layout_chg = |chg_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++)
        if (hit[i]) cfg_q[i] <= wr_data;
    end
  end

  assign len_flat[0 +: SUM_W]     = SUM_W'(EP0_BYTES);
  assign len_flat[SUM_W +: SUM_W] = SUM_W'(EP0_BYTES);

  genvar g;
  generate
    for (g = 0; g < NUM_CFG; g++) begin : g_ep
      ep_cfg_t c;
      assign c = ep_cfg_t'(cfg_q[g]);
      assign len_flat[(g + 2)*SUM_W +: SUM_W] = SUM_W'(slot_bytes(c));
      assign dir_cfg[g] = c.dir;
    end
  endgenerate

  AST_IGNORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_ep == '0 || wr_ep > EP_W'(NUM_CFG)) |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/ep_layout_seq.sv
module ep_layout_seq #(
  parameter int NEP      = 16,
  parameter int SUM_W    = 16,
  parameter int CAPACITY = 2462,
  localparam int IDX_W = $clog2(NEP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NEP*SUM_W-1:0] len_flat,
  output logic [NEP*SUM_W-1:0] base_flat,
  output logic                 busy,
  output logic                 overflow
);

  logic [NEP-1:0][SUM_W-1:0] base_q;
  logic [IDX_W-1:0]          idx;
  logic [SUM_W-1:0]          acc;
  logic [SUM_W-1:0]          acc_next;
  logic                      last;
  logic                      step_done;

  assign acc_next  = acc + len_flat[idx*SUM_W +: SUM_W];
  assign last      = (idx == IDX_W'(NEP - 1));
  assign step_done = busy && last && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      idx      <= '0;
      acc      <= '0;
      base_q   <= '0;
      overflow <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      acc  <= '0;
    end else if (busy) begin
      base_q[idx] <= acc;
      acc         <= acc_next;
      idx         <= idx + 1'b1;
      if (last) begin
        busy     <= 1'b0;
        overflow <= (acc_next > SUM_W'(CAPACITY));
      end
    end
  end

  assign base_flat = base_q;

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !busy); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && idx == '0); // R8

endmodule

// File: rtl/ep_valid_track.sv
module ep_valid_track #(
  parameter int NEP = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           busy,
  input  logic [NEP-1:0] set,
  input  logic [NEP-1:0] len_nz,
  output logic [NEP-1:0] valid
);

  logic [NEP-1:0] set_ok;
  assign set_ok = set & len_nz & {NEP{!busy}};

  always_ff @(posedge clk) begin
    if (rst)      valid <= '0;
    else if (clr) valid <= '0;
    else          valid <= valid | set_ok;
  end

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    clr |=> valid == '0); // R10
  AST_NO_FILL_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && !clr |=> valid == $past(valid)); // R11

endmodule

// File: rtl/usb_ep_alloc.sv
module usb_ep_alloc
  import usb_ep_alloc_pkg::*;
#(
  parameter int NUM_CFG   = 14,
  parameter int SUM_W     = 16,
  parameter int EP0_BYTES = 64,
  parameter int CAPACITY  = 2462,
  localparam int NEP  = NUM_CFG + 2,
  localparam int EP_W = $clog2(NUM_CFG + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [EP_W-1:0]      cfg_ep,
  input  logic [7:0]           cfg_wdata,
  input  logic [NEP-1:0]       fill_set,
  output logic [NEP*SUM_W-1:0] base_o,
  output logic [NEP*SUM_W-1:0] len_o,
  output logic [NEP-1:0]       dir_o,
  output logic [NEP-1:0]       valid_o,
  output logic                 busy_o,
  output logic                 overflow_o
);

  logic               layout_chg;
  logic [NUM_CFG-1:0] dir_cfg;
  logic [NEP-1:0]     len_nz;
  logic [SUM_W-1:0]   end_addr;

  ep_cfg_regs #(.NUM_CFG(NUM_CFG), .SUM_W(SUM_W), .EP0_BYTES(EP0_BYTES)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_ep(cfg_ep), .wr_data(cfg_wdata),
    .len_flat(len_o), .dir_cfg(dir_cfg), .layout_chg(layout_chg)
  );

  ep_layout_seq #(.NEP(NEP), .SUM_W(SUM_W), .CAPACITY(CAPACITY)) u_seq (
    .clk(clk), .rst(rst), .start(layout_chg), .len_flat(len_o),
    .base_flat(base_o), .busy(busy_o), .overflow(overflow_o)
  );

  genvar g;
  generate
    for (g = 0; g < NEP; g++) begin : g_nz
      assign len_nz[g] = |len_o[g*SUM_W +: SUM_W];
      AST_NO_EMPTY_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_o[g] |-> len_nz[g]); // R11
    end
    for (g = 0; g < NEP - 1; g++) begin : g_chain
      AST_PACKED_CHAIN: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> base_o[(g + 1)*SUM_W +: SUM_W] ==
                    base_o[g*SUM_W +: SUM_W] + len_o[g*SUM_W +: SUM_W]); // R7
    end
  endgenerate

  ep_valid_track #(.NEP(NEP)) u_valid (
    .clk(clk), .rst(rst), .clr(layout_chg), .busy(busy_o),
    .set(fill_set), .len_nz(len_nz), .valid(valid_o)
  );

  assign dir_o    = {dir_cfg, 1'b1, 1'b0};
  assign end_addr = base_o[(NEP - 1)*SUM_W +: SUM_W] + len_o[(NEP - 1)*SUM_W +: SUM_W];

  AST_EP0_FIXED: assert property (@(posedge clk) disable iff (rst)
    len_o[0 +: SUM_W] == SUM_W'(EP0_BYTES) && len_o[SUM_W +: SUM_W] == SUM_W'(EP0_BYTES)); // R1
  AST_EP0_BASES: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> base_o[0 +: SUM_W] == '0 && base_o[SUM_W +: SUM_W] == SUM_W'(EP0_BYTES)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> overflow_o == (end_addr > SUM_W'(CAPACITY))); // R9
  AST_CHANGE_BUSY: assert property (@(posedge clk) disable iff (rst)
    layout_chg |=> busy_o); // R8

endmodule

// File: tb/usb_ep_alloc_tb.sv
`timescale 1ns/1ps
module usb_ep_alloc_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_ep = '0;
  logic [7:0]   cfg_wdata = '0;
  logic [15:0]  fill_set = '0;
  logic [255:0] base_o, len_o;
  logic [15:0]  dir_o, valid_o;
  logic         busy_o, overflow_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  usb_ep_alloc u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_wdata(cfg_wdata),
    .fill_set(fill_set), .base_o(base_o), .len_o(len_o), .dir_o(dir_o),
    .valid_o(valid_o), .busy_o(busy_o), .overflow_o(overflow_o)
  );

  // ---------------- reference model ----------------
  int iso_tbl[16] = '{16, 32, 48, 64, 96, 128, 160, 192, 256, 320, 384, 512, 640, 768, 896, 1023};
  logic [7:0]  m_cfg[1:14];
  int          m_cnt;
  logic [15:0] m_valid;

  function automatic int m_len(int b);
    logic [7:0] c;
    int p;
    if (b < 2) return 64;
    c = m_cfg[b - 1];
    if (!c[0]) return 0;
    p = c[1] ? iso_tbl[c[7:4]] : (c[7:4] < 4 ? (8 << c[7:4]) : 64);
    return c[3] ? 2 * p : p;
  endfunction

  function automatic int key_of(logic [7:0] c);
    return c[0] ? {1'b1, c[1], c[3], c[7:4]} : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int e = 1; e <= 14; e++) m_cfg[e] = 8'h00;
      m_cnt = 16;
      m_valid = '0;
    end else begin
      bit chg;
      bit busy_pre;
      busy_pre = (m_cnt > 0);
      chg = 1'b0;
      if (cfg_we && cfg_ep >= 1 && cfg_ep <= 14) begin
        if (key_of(m_cfg[cfg_ep]) != key_of(cfg_wdata)) chg = 1'b1;
        if (!chg) m_cfg[cfg_ep] = cfg_wdata;
      end
      if (chg) begin
        m_cfg[cfg_ep] = cfg_wdata;
        m_cnt = 16;
        m_valid = '0;
      end else begin
        for (int b = 0; b < 16; b++)
          if (fill_set[b] && !busy_pre && m_len(b) > 0) m_valid[b] = 1'b1;
        if (m_cnt > 0) m_cnt--;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int dbase(int b);
    return int'(base_o[b*16 +: 16]);
  endfunction
  function automatic int dlen(int b);
    return int'(len_o[b*16 +: 16]);
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int sum;
      chk(int'(busy_o), int'(m_cnt > 0), "R8 busy");
      sum = 0;
      for (int b = 0; b < 16; b++) begin
        chk(dlen(b), m_len(b), $sformatf("R3/R4/R5/R6 len buf%0d", b));
        chk(int'(dir_o[b]), b < 2 ? b : int'(m_cfg[b - 1][2]), $sformatf("R1/R2 dir buf%0d", b));
        if (m_cnt == 0) chk(dbase(b), sum, $sformatf("R7 base buf%0d", b));
        sum += m_len(b);
      end
      if (m_cnt == 0) begin
        chk(int'(overflow_o), int'(sum > 2462), "R9 overflow");
        chk(int'(valid_o), int'(m_valid), "R10/R11 valid");
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [7:0] mk(int size, bit dbl, bit dir, bit iso, bit en);
    return {size[3:0], dbl, dir, iso, en};
  endfunction

  task automatic wr(input int ep, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = ep[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input logic [15:0] m);
    @(negedge clk);
    fill_set = m;
    @(negedge clk);
    fill_set = '0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R12 reset layout
    chk(dbase(1), 64, "R1 ep0 IN base");
    chk(dbase(2), 128, "R12 buf2 base");
    chk(dbase(15), 128, "R12 buf15 base");
    chk(dlen(9), 0, "R12 buf9 len");
    chk(int'(overflow_o), 0, "R12 overflow");
    chk(int'(valid_o), 0, "R12 valid");

    wr(1, mk(3, 0, 0, 0, 1));
    wr(2, mk(0, 0, 1, 0, 1));
    wr(3, mk(7, 0, 0, 0, 0));
    wr(4, mk(15, 0, 0, 1, 1));
    wr(5, mk(5, 1, 1, 1, 1));
    wr(6, mk(9, 0, 0, 0, 1));
    settle();
    chk(dlen(2), 64, "R3 code3");
    chk(dlen(3), 8, "R3 code0");
    chk(dlen(7), 64, "R3 code9 clamps");
    chk(dlen(5), 1023, "R4 iso code15");
    chk(dlen(6), 256, "R5 iso code5 doubled");
    chk(dlen(4), 0, "R6 disabled");
    chk(dbase(5), 200, "R7 base after disabled");
    chk(dbase(4), dbase(5), "R6 disabled takes no space");

    wr(0, mk(15, 1, 1, 1, 1));
    chk(int'(busy_o), 0, "R2 ep0 write ignored");
    wr(15, mk(15, 1, 1, 1, 1));
    chk(int'(busy_o), 0, "R2 ep15 write ignored");

    fill(16'hFFFF);
    chk(int'(valid_o), 16'h00EF, "R11 fill idle");

    wr(1, mk(3, 0, 1, 0, 1));
    chk(int'(busy_o), 0, "R8 dir-only no busy");
    chk(int'(valid_o), 16'h00EF, "R10 dir-only keeps valid");
    wr(3, mk(2, 1, 0, 1, 0));
    chk(int'(busy_o), 0, "R8 disabled edit no busy");
    chk(int'(valid_o), 16'h00EF, "R10 disabled edit keeps valid");

    wr(3, mk(2, 0, 0, 0, 1));
    chk(int'(busy_o), 1, "R8 enable raises busy");
    chk(int'(valid_o), 0, "R10 enable clears valid");
    fill(16'hFFFF);
    settle();
    chk(int'(valid_o), 0, "R11 fill during busy ignored");

    // exact capacity: 128 + 2046 + 256 + 32 = 2462
    wr(4, 8'h00); wr(5, 8'h00); wr(6, 8'h00);
    wr(1, mk(15, 1, 0, 1, 1));
    wr(2, mk(8, 0, 0, 1, 1));
    wr(3, mk(2, 0, 0, 0, 1));
    settle();
    chk(int'(overflow_o), 0, "R9 exactly full");
    wr(3, mk(3, 0, 0, 0, 1));
    settle();
    chk(int'(overflow_o), 1, "R9 over by 32");

    // restart while busy
    wr(2, mk(9, 0, 0, 1, 1));
    repeat (6) @(negedge clk);
    wr(2, mk(10, 0, 0, 1, 1));
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      @(negedge clk);
    end
    chk(n, 16, "R8 restart window");
    settle();

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    settle();
    chk(dlen(2), 0, "R12 reset disables");
    chk(dbase(15), 128, "R12 reset base");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule